// File: doc/BRIEF.md
# DLL Start-Up Sequencer

This block brings a memory PHY's delay-locked loops out of reset in a fixed, timed order. One master DLL and up to four per-byte-lane slave DLLs each own a control word made of a phase field, a disable bit and an active-low reset bit. A start strobe launches a run that walks the selected DLLs through three timed phases. A run either covers the master DLL alone or covers the slave lanes. In a slave run every active lane moves in lockstep. The delays are counted in microsecond ticks supplied from outside.

Software or a boot engine first runs the master DLL, then runs the slave lanes. The phase word is shared by both runs. The master takes a six-bit slice from its upper half. Each slave lane takes its own nibble from the low end. With a 32-bit data bus, four slave lanes take part in a run. With a 16-bit bus only lanes 1 and 2 do, and lanes 3 and 4 keep whatever they held before. A one-cycle done pulse marks the end of each run.

Top module: `dll_start_seq`

## Requirements
- R1: After reset every control word (`master_ctrl_o`, all lanes of `lane_ctrl_o`) reads zero and `done_o` is low.
- R2: A start with `slave_run_i`=0 sets the master word to disable (bit 31)=1, reset-n (bit 30)=0 and phase bits [11:6]=`phase_word_i[21:16]` at the accepting edge. No lane word changes.
- R3: A start with `slave_run_i`=1 loads slave lane i (1-based, word i-1 at `lane_ctrl_o[32(i-1)+:32]`) with phase bits [17:14]=`phase_word_i[4(i-1)+3:4(i-1)]`, disable=1 and reset-n=0. The master word does not change.
- R4: With `wide_bus_i`=1 a slave run drives lanes 1 to 4. With `wide_bus_i`=0 it drives only lanes 1 and 2, and lanes 3 and 4 keep their previous contents.
- R5: The first phase (disable=1, reset-n=0) lasts 2 ticks. At the edge that samples the second tick, the words go to disable=0, reset-n=0.
- R6: The second phase lasts 22 ticks. At the edge that samples its 22nd tick, the words go to disable=0, reset-n=1.
- R7: The third phase lasts 22 ticks. At the edge that samples its last tick, `done_o` rises for exactly one cycle and the words keep their third-phase values.
- R8: A start during a run is ignored. No phase field is reloaded, and the timing and the done cycle stay as they were.
- R9: Cycles without `us_tick_i` do not advance a run.
- R10: No control word ever has disable and reset-n set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| slave_run_i | input | 1 | 0: master-only run, 1: slave-lane run |
| wide_bus_i | input | 1 | 1: 32-bit bus (4 lanes), 0: 16-bit bus (2 lanes) |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| phase_word_i | input | 32 | Packed phase settings |
| master_ctrl_o | output | 32 | Master DLL control word |
| lane_ctrl_o | output | 128 | Slave lane control words, lane 1 in the low 32 bits |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench goes after phase boundaries at tick counts 2, 24 and 46. A design off by one tick there would show the wrong disable/reset-n pair at exactly those samples, or pulse done one tick early or late. Narrow-bus runs follow wide ones, so a design that touched lanes 3 and 4 on a 16-bit bus would overwrite nibbles left from the earlier run. A start injected mid-run with a different phase word and mode catches a design that restarts or reloads the fields. Idle gaps between ticks expose a counter that advances on the clock instead of on the tick.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_HOLD    = 2'd1,
      ST_RELEASE = 2'd2,
      ST_RUN     = 2'd3
   } step_e;

   typedef struct packed {
      logic dis;
      logic rstn;
   } ctl_pair_t;

   function automatic step_e next_step(step_e s);
      case (s)
         ST_IDLE:    return ST_HOLD;
         ST_HOLD:    return ST_RELEASE;
         ST_RELEASE: return ST_RUN;
         default:    return ST_IDLE;
      endcase
   endfunction

   function automatic ctl_pair_t pair_for(step_e s);
      ctl_pair_t p;
      case (s)
         ST_HOLD:    p = '{dis: 1'b1, rstn: 1'b0};
         ST_RELEASE: p = '{dis: 1'b0, rstn: 1'b0};
         ST_RUN:     p = '{dis: 1'b0, rstn: 1'b1};
         default:    p = '{dis: 1'b0, rstn: 1'b0};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/dll_us_timer.sv
module dll_us_timer #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             last_o
);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("dll_us_timer: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign last_o = tick_i && (cnt_q == limit_i - CNT_W'(1));

   // R9
   tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clr_i) |=> $stable(cnt_q));

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < limit_i);

endmodule

// File: rtl/dll_step_fsm.sv
module dll_step_fsm
   import dll_seq_pkg::*;
#(
   parameter int unsigned T_HOLD    = 2,
   parameter int unsigned T_RELEASE = 22,
   parameter int unsigned T_RUN     = 22
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic tick_i,
   input  logic slave_i,
   input  logic wide_i,
   output logic apply_o,
   output logic load_o,
   output logic dis_o,
   output logic rstn_o,
   output logic slave_o,
   output logic wide_o,
   output logic done_o
);

   localparam int unsigned T_MAX1 = (T_HOLD > T_RELEASE) ? T_HOLD : T_RELEASE;
   localparam int unsigned T_MAX  = (T_MAX1 > T_RUN) ? T_MAX1 : T_RUN;
   localparam int unsigned CNT_W  = $clog2(T_MAX + 1);

   generate
      if (T_HOLD == 0 || T_RELEASE == 0 || T_RUN == 0) begin : g_bad_t
         $error("dll_step_fsm: every step needs at least one tick");
      end
   endgenerate

   step_e            state_q, state_d;
   logic             slave_q, wide_q, done_q;
   logic [CNT_W-1:0] limit;
   logic             last, idle, accept, adv, clr;
   ctl_pair_t        pair;

   assign idle   = (state_q == ST_IDLE);
   assign accept = idle && start_i;
   assign adv    = !idle && last;
   assign clr    = idle || adv;

   always_comb begin
      case (state_q)
         ST_RELEASE: limit = CNT_W'(T_RELEASE);
         ST_RUN:     limit = CNT_W'(T_RUN);
         default:    limit = CNT_W'(T_HOLD);
      endcase
   end

   dll_us_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .tick_i  (tick_i),
      .limit_i (limit),
      .last_o  (last)
   );

   always_comb begin
      state_d = state_q;
      if (accept)   state_d = ST_HOLD;
      else if (adv) state_d = next_step(state_q);
   end

   assign pair    = pair_for(accept ? ST_HOLD : next_step(state_q));
   assign apply_o = accept || (adv && (state_q != ST_RUN));
   assign load_o  = accept;
   assign dis_o   = pair.dis;
   assign rstn_o  = pair.rstn;
   assign slave_o = idle ? slave_i : slave_q;
   assign wide_o  = idle ? wide_i  : wide_q;
   assign done_o  = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slave_q <= 1'b0;
         wide_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= adv && (state_q == ST_RUN);
         if (accept) begin
            slave_q <= slave_i;
            wide_q  <= wide_i;
         end
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (state_q == ST_IDLE));

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && start_i && !last) |=> $stable(state_q) && $stable(slave_q) && $stable(wide_q));

endmodule

// File: rtl/dll_ctrl_reg.sv
module dll_ctrl_reg #(
   parameter int unsigned CTRL_W   = 32,
   parameter int unsigned PH_W     = 4,
   parameter int unsigned PH_LSB   = 14,
   parameter int unsigned DIS_BIT  = 31,
   parameter int unsigned RSTN_BIT = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              apply_i,
   input  logic              load_i,
   input  logic              en_i,
   input  logic [PH_W-1:0]   phase_i,
   input  logic              dis_i,
   input  logic              rstn_i,
   output logic [CTRL_W-1:0] ctrl_o
);

   generate
      if (PH_LSB + PH_W > CTRL_W) begin : g_bad_field
         $error("dll_ctrl_reg: phase field outside the word");
      end
      if (DIS_BIT >= CTRL_W || RSTN_BIT >= CTRL_W || DIS_BIT == RSTN_BIT) begin : g_bad_bits
         $error("dll_ctrl_reg: control bit positions invalid");
      end
      if ((DIS_BIT >= PH_LSB && DIS_BIT < PH_LSB + PH_W) ||
          (RSTN_BIT >= PH_LSB && RSTN_BIT < PH_LSB + PH_W)) begin : g_overlap
         $error("dll_ctrl_reg: control bit overlaps phase field");
      end
   endgenerate

   logic [PH_W-1:0] ph_q;
   logic            dis_q, rstn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= '0;
         dis_q  <= 1'b0;
         rstn_q <= 1'b0;
      end else if (apply_i && en_i) begin
         dis_q  <= dis_i;
         rstn_q <= rstn_i;
         if (load_i) ph_q <= phase_i;
      end
   end

   always_comb begin
      ctrl_o                     = '0;
      ctrl_o[PH_LSB +: PH_W]     = ph_q;
      ctrl_o[DIS_BIT]            = dis_q;
      ctrl_o[RSTN_BIT]           = rstn_q;
   end

   // R10
   no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_o[DIS_BIT] && ctrl_o[RSTN_BIT]));

   // R8
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(apply_i && load_i && en_i) |=> $stable(ctrl_o[PH_LSB +: PH_W]));

endmodule

// File: rtl/dll_start_seq.sv
module dll_start_seq
   import dll_seq_pkg::*;
#(
   parameter int unsigned LANES        = 4,
   parameter int unsigned NARROW_LANES = 2,
   parameter int unsigned PHASE_W      = 32,
   parameter int unsigned CTRL_W       = 32,
   parameter int unsigned SL_PH_W      = 4,
   parameter int unsigned SL_PH_LSB    = 14,
   parameter int unsigned M_PH_W       = 6,
   parameter int unsigned M_PH_LSB     = 6,
   parameter int unsigned M_PH_SRC     = 16,
   parameter int unsigned DIS_BIT      = 31,
   parameter int unsigned RSTN_BIT     = 30,
   parameter int unsigned T_HOLD_US    = 2,
   parameter int unsigned T_RELEASE_US = 22,
   parameter int unsigned T_RUN_US     = 22
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    slave_run_i,
   input  logic                    wide_bus_i,
   input  logic                    us_tick_i,
   input  logic [PHASE_W-1:0]      phase_word_i,
   output logic [CTRL_W-1:0]       master_ctrl_o,
   output logic [LANES*CTRL_W-1:0] lane_ctrl_o,
   output logic                    done_o
);

   localparam int unsigned LCNT_W = $clog2(LANES + 1);

   generate
      if (LANES * SL_PH_W > PHASE_W) begin : g_bad_lanes
         $error("dll_start_seq: lane phase nibbles exceed the phase word");
      end
      if (M_PH_SRC + M_PH_W > PHASE_W) begin : g_bad_master
         $error("dll_start_seq: master phase slice exceeds the phase word");
      end
      if (NARROW_LANES == 0 || NARROW_LANES > LANES) begin : g_bad_narrow
         $error("dll_start_seq: NARROW_LANES out of range");
      end
   endgenerate

   logic              apply, load, dis, rstn, slave_eff, wide_eff;
   logic [LCNT_W-1:0] active_cnt;

   dll_step_fsm #(
      .T_HOLD    (T_HOLD_US),
      .T_RELEASE (T_RELEASE_US),
      .T_RUN     (T_RUN_US)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .tick_i  (us_tick_i),
      .slave_i (slave_run_i),
      .wide_i  (wide_bus_i),
      .apply_o (apply),
      .load_o  (load),
      .dis_o   (dis),
      .rstn_o  (rstn),
      .slave_o (slave_eff),
      .wide_o  (wide_eff),
      .done_o  (done_o)
   );

   assign active_cnt = wide_eff ? LCNT_W'(LANES) : LCNT_W'(NARROW_LANES);

   dll_ctrl_reg #(
      .CTRL_W   (CTRL_W),
      .PH_W     (M_PH_W),
      .PH_LSB   (M_PH_LSB),
      .DIS_BIT  (DIS_BIT),
      .RSTN_BIT (RSTN_BIT)
   ) u_master (
      .clk     (clk),
      .rst_n   (rst_n),
      .apply_i (apply),
      .load_i  (load),
      .en_i    (!slave_eff),
      .phase_i (phase_word_i[M_PH_SRC +: M_PH_W]),
      .dis_i   (dis),
      .rstn_i  (rstn),
      .ctrl_o  (master_ctrl_o)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic lane_en;
         assign lane_en = slave_eff && (LCNT_W'(g) < active_cnt);

         dll_ctrl_reg #(
            .CTRL_W   (CTRL_W),
            .PH_W     (SL_PH_W),
            .PH_LSB   (SL_PH_LSB),
            .DIS_BIT  (DIS_BIT),
            .RSTN_BIT (RSTN_BIT)
         ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .apply_i (apply),
            .load_i  (load),
            .en_i    (lane_en),
            .phase_i (phase_word_i[g*SL_PH_W +: SL_PH_W]),
            .dis_i   (dis),
            .rstn_i  (rstn),
            .ctrl_o  (lane_ctrl_o[g*CTRL_W +: CTRL_W])
         );
      end

      if (NARROW_LANES < LANES) begin : g_narrow_chk
         // R4
         upper_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wide_eff |=> $stable(lane_ctrl_o[LANES*CTRL_W-1 : NARROW_LANES*CTRL_W]));
      end
   endgenerate

   // R2
   master_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_eff |=> $stable(lane_ctrl_o));

   // R3
   lanes_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slave_eff |=> $stable(master_ctrl_o));

endmodule

// File: tb/dll_start_seq_tb.sv
module dll_start_seq_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         slave_run_i = 1'b0;
   logic         wide_bus_i = 1'b0;
   logic         us_tick_i = 1'b0;
   logic [31:0]  phase_word_i = '0;
   logic [31:0]  master_ctrl_o;
   logic [127:0] lane_ctrl_o;
   logic         done_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   dll_start_seq u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .slave_run_i   (slave_run_i),
      .wide_bus_i    (wide_bus_i),
      .us_tick_i     (us_tick_i),
      .phase_word_i  (phase_word_i),
      .master_ctrl_o (master_ctrl_o),
      .lane_ctrl_o   (lane_ctrl_o),
      .done_o        (done_o)
   );

   // expected model state
   logic [5:0] m_ph;
   logic       m_dis, m_rstn;
   logic [3:0] l_ph   [4];
   logic       l_dis  [4];
   logic       l_rstn [4];

   function automatic logic [31:0] word_of(int lsb, logic [5:0] ph, logic d, logic r);
      logic [31:0] w;
      w = 32'(ph) << lsb;
      w[31] = d;
      w[30] = r;
      return w;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_all(string req);
      chk(req, master_ctrl_o, word_of(6, m_ph, m_dis, m_rstn));
      for (int i = 0; i < 4; i++)
         chk(req, lane_ctrl_o[i*32 +: 32], word_of(14, {2'b00, l_ph[i]}, l_dis[i], l_rstn[i]));
   endtask

   task automatic model_set(bit slave, bit wide, logic [31:0] ph, bit d, bit r, bit load);
      if (!slave) begin
         m_dis = d; m_rstn = r;
         if (load) m_ph = ph[21:16];
      end else begin
         for (int i = 0; i < (wide ? 4 : 2); i++) begin
            l_dis[i] = d; l_rstn[i] = r;
            if (load) l_ph[i] = ph[i*4 +: 4];
         end
      end
   endtask

   task automatic run_seq(bit slave, bit wide, logic [31:0] ph, int gap, bit inject);
      string rq;
      @(negedge clk);
      start_i = 1'b1; slave_run_i = slave; wide_bus_i = wide; phase_word_i = ph;
      @(negedge clk);
      start_i = 1'b0;
      model_set(slave, wide, ph, 1'b1, 1'b0, 1'b1);
      rq = slave ? (wide ? "R3" : "R4") : "R2";
      check_all(rq);
      chk("R7", 32'(done_o), 32'd0);
      for (int t = 1; t <= 46; t++) begin
         repeat (gap) @(negedge clk);
         if (gap > 0 && t == 5) check_all("R9");
         us_tick_i = 1'b1;
         if (inject && t == 10) begin
            start_i = 1'b1; slave_run_i = ~slave; wide_bus_i = ~wide;
            phase_word_i = ~ph;
         end
         @(negedge clk);
         us_tick_i = 1'b0;
         start_i = 1'b0;
         if (t == 2)  model_set(slave, wide, ph, 1'b0, 1'b0, 1'b0);
         if (t == 24) model_set(slave, wide, ph, 1'b0, 1'b1, 1'b0);
         if (t <= 2)       rq = "R5";
         else if (t <= 24) rq = "R6";
         else              rq = "R7";
         if (inject && t > 10) rq = "R8";
         check_all(rq);
         chk(inject ? "R8" : "R7", 32'(done_o), 32'(t == 46));
      end
      @(negedge clk);
      chk("R7", 32'(done_o), 32'd0);
      check_all("R7");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_ph = '0; m_dis = 1'b0; m_rstn = 1'b0;
      for (int i = 0; i < 4; i++) begin
         l_ph[i] = '0; l_dis[i] = 1'b0; l_rstn[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      check_all("R1");
      chk("R1", 32'(done_o), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_all("R1");

      // R2: master run with all-ones slice
      run_seq(1'b0, 1'b0, 32'h003F_0000, 0, 1'b0);
      // R3: wide slave run, with idle gaps between ticks (R9)
      run_seq(1'b1, 1'b1, 32'h0000_ABCD, 2, 1'b0);
      // R4: narrow slave run leaves lanes 3 and 4 from previous run
      run_seq(1'b1, 1'b0, 32'h0000_1234, 1, 1'b0);
      // R8: start during a run is ignored
      run_seq(1'b0, 1'b1, 32'h0015_5A5A, 0, 1'b1);
      run_seq(1'b1, 1'b0, 32'h0000_00F0, 1, 1'b1);

      for (int k = 0; k < 6; k++) begin
         logic [31:0] ph;
         ph = $urandom;
         run_seq(1'($urandom % 2), 1'($urandom % 2), ph, int'($urandom % 4), 1'($urandom % 2));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule